// File: doc/BRIEF.md
# Compressed-to-Native Instruction Expander

This block takes one 16-bit compressed instruction per accepted transfer and produces the equivalent 32-bit native instruction word for a small supported subset. That subset is register add-with-carry, add of a 3-bit immediate and add of an 8-bit immediate. Each expanded word has its condition field forced to "always" and its flag-update bit set. Every 3-bit register index is widened to a 4-bit field whose top bit is zero.

Besides expanding, the block sorts every input into one of six classes: expanded, software interrupt, prefetch abort, debug halt, undefined and unsupported. For the two exception-generating encodings, the 8-bit immediate is passed out on a side output so that a later handler can use it. A breakpoint goes to the prefetch-abort class unless the debug override input is high when that breakpoint is accepted.

The input uses a valid/ready handshake. The result sits in a single registered stage that holds while the consumer stalls. The stage can take a new input in the same cycle as it hands off the old one.

Top module: `narrow_insn_expander`

## Requirements
- R1: An input with bits 15:6 = 0100000101 (m = bits 5:3, d = bits 2:0) has class 0 and word {12'hE0B, 0,d, 0,d, 8'h00, 0,m}.
- R2: An input with bits 15:9 = 0001110 (k = bits 8:6, n = bits 5:3, d = bits 2:0) has class 0 and word {12'hE29, 0,n, 0,d, 9'b0, k}.
- R3: An input with bits 15:11 = 00110 (d = bits 10:8, k = bits 7:0) has class 0 and word {12'hE29, 0,d, 0,d, 4'h0, k}.
- R4: In every class-0 word, bits 19 and 15 (the top bits of the two widened register fields) are 0.
- R5: Bits 15:8 = 8'hDF give class 1. For classes 1, 2 and 3 the tag output equals input bits 7:0, and those bits never change the class.
- R6: Bits 15:8 = 8'hBE give class 2 when debug_override is low at acceptance, and class 3 when it is high.
- R7: The inputs 10110001xxxxxxxx, 10110x1xxxxxxxxx, 101110xxxxxxxxxx, 10111111xxxxxxxx and 11011110xxxxxxxx give class 4.
- R8: Any other input gives class 5. Whenever the class is not 0 the word is zero, and for classes 0, 4 and 5 the tag is zero.
- R9: in_ready is high when out_valid is low or out_ready is high. An input is accepted when in_valid and in_ready are both high, and its result is valid in the next cycle. While out_valid is high and out_ready is low, all outputs hold.
- R10: A synchronous active-high reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input instruction present |
| in_ready | output | 1 | Block can take an instruction |
| in_insn | input | 16 | Compressed instruction |
| debug_override | input | 1 | Turns breakpoints into debug halt |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Expanded native instruction or zero |
| out_class | output | 3 | 0 expanded, 1 sw interrupt, 2 prefetch abort, 3 debug halt, 4 undefined, 5 unsupported |
| out_tag | output | 8 | Immediate of an exception-generating input |

## Verification
The key collision is a hand-off and a new acceptance in the same cycle. The result stage empties and refills on one edge, and a stalled result must not be overwritten by a waiting input. Random in_valid and out_ready patterns create both overlapping transfers and long stalls. A behavioural queue-free model of the stage is compared with every output each cycle. Classification is swept over all 256 upper-byte values, with random lower bytes and random override, so that every boundary of the undefined ranges meets the breakpoint and interrupt encodings.

// File: rtl/narrow_insn_expander.sv
module narrow_insn_expander (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_insn,
  input  logic        debug_override,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word,
  output logic [2:0]  out_class,
  output logic [7:0]  out_tag
);

  localparam logic [2:0] C_EXP = 3'd0, C_SWI = 3'd1, C_PAB = 3'd2,
                         C_DBG = 3'd3, C_UND = 3'd4, C_UNS = 3'd5;

  logic [7:0]  hi;
  logic [31:0] nx_word;
  logic [2:0]  nx_class;
  logic [7:0]  nx_tag;
  logic        undef_hit;
  logic        take;

  assign hi   = in_insn[15:8];
  assign take = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  assign undef_hit = (hi == 8'b1011_0001) ||
                     (hi[7:3] == 5'b10110 && hi[1]) ||
                     (hi[7:2] == 6'b101110) ||
                     (hi == 8'b1011_1111) ||
                     (hi == 8'b1101_1110);

  always_comb begin
    nx_word  = '0;
    nx_class = C_UNS;
    nx_tag   = '0;
    if (undef_hit) begin
      nx_class = C_UND;
    end else if (hi == 8'hDF) begin
      nx_class = C_SWI;
      nx_tag   = in_insn[7:0];
    end else if (hi == 8'hBE) begin
      nx_class = debug_override ? C_DBG : C_PAB;
      nx_tag   = in_insn[7:0];
    end else if (in_insn[15:6] == 10'b01_0000_0101) begin
      nx_class = C_EXP;
      nx_word  = {12'hE0B, 1'b0, in_insn[2:0], 1'b0, in_insn[2:0], 8'h00, 1'b0, in_insn[5:3]};
    end else if (in_insn[15:9] == 7'b000_1110) begin
      nx_class = C_EXP;
      nx_word  = {12'hE29, 1'b0, in_insn[5:3], 1'b0, in_insn[2:0], 9'b0, in_insn[8:6]};
    end else if (in_insn[15:11] == 5'b00110) begin
      nx_class = C_EXP;
      nx_word  = {12'hE29, 1'b0, in_insn[10:8], 1'b0, in_insn[10:8], 4'h0, in_insn[7:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_word  <= nx_word;
      out_class <= nx_class;
      out_tag   <= nx_tag;
    end
  end

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) &&
                                   $stable(out_class) && $stable(out_tag))); // R9

  AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R9

  AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_class <= C_UNS)); // R8

  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class != C_EXP) |-> (out_word == 32'h0)); // R8

  AST_REG_WIDEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == C_EXP) |-> (!out_word[19] && !out_word[15])); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid); // R10

endmodule

// File: tb/narrow_insn_expander_bench.sv
`timescale 1ns/1ps
module narrow_insn_expander_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_insn;
  logic        debug_override;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_word;
  logic [2:0]  out_class;
  logic [7:0]  out_tag;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  narrow_insn_expander u_narrow_insn_expander (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .debug_override(debug_override),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_class(out_class), .out_tag(out_tag));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural expectation built from the requirements
  task automatic ref_model(input logic [15:0] x, input logic dbg,
                           output logic [31:0] w, output int cls,
                           output logic [7:0] tg, output string req);
    logic [3:0] d, n, m;
    w = 0; tg = 0;
    if (x ==? 16'b10110001_????????) begin cls = 4; req = "R7"; end
    else if (x ==? 16'b10110?1?_????????) begin cls = 4; req = "R7"; end
    else if (x ==? 16'b101110??_????????) begin cls = 4; req = "R7"; end
    else if (x ==? 16'b10111111_????????) begin cls = 4; req = "R7"; end
    else if (x ==? 16'b11011110_????????) begin cls = 4; req = "R7"; end
    else if (x[15:8] == 8'hDF) begin cls = 1; tg = x[7:0]; req = "R5"; end
    else if (x[15:8] == 8'hBE) begin cls = dbg ? 3 : 2; tg = x[7:0]; req = "R6"; end
    else if (x ==? 16'b0100000101_??????) begin
      cls = 0; req = "R1"; d = {1'b0, x[2:0]}; m = {1'b0, x[5:3]};
      w = 32'hE0B0_0000 | (32'(d) << 16) | (32'(d) << 12) | 32'(m);
    end else if (x ==? 16'b0001110_?????????) begin
      cls = 0; req = "R2"; d = {1'b0, x[2:0]}; n = {1'b0, x[5:3]};
      w = 32'hE290_0000 | (32'(n) << 16) | (32'(d) << 12) | 32'(x[8:6]);
    end else if (x ==? 16'b00110_???????????) begin
      cls = 0; req = "R3"; d = {1'b0, x[10:8]};
      w = 32'hE290_0000 | (32'(d) << 16) | (32'(d) << 12) | 32'(x[7:0]);
    end else begin cls = 5; req = "R8"; end
  endtask

  function automatic logic [15:0] gen(input int idx);
    int sel;
    if (idx < 512) return {8'(idx / 2), 8'($urandom)};
    sel = $urandom_range(0, 5);
    case (sel)
      0: return {10'b0100000101, 6'($urandom)};
      1: return {7'b0001110, 9'($urandom)};
      2: return {5'b00110, 11'($urandom)};
      3: return {8'hDF, 8'($urandom)};
      4: return {8'hBE, 8'($urandom)};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(20000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic        ev, nv, acc;
    logic [31:0] ew, nw;
    int          ec, nc;
    logic [7:0]  et, nt;
    string       er, nr;
    int          idx;
    logic        ers;
    ev = 0; ew = 0; ec = 0; et = 0; er = "R1"; idx = 0;
    rst = 1; in_valid = 0; out_ready = 0; in_insn = 0; debug_override = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "out_valid after reset", out_valid, 0);
    rst = 0;
    in_insn = gen(idx);
    for (int cyc = 0; cyc < 15000 && idx < 2500; cyc++) begin
      ers = !ev || out_ready;
      chk("R9", "in_ready", in_ready, ers);
      chk("R9", "out_valid", out_valid, ev);
      if (ev) begin
        chk(er, "class", out_class, ec);
        chk(er, "word", out_word, ew);
        chk(ec inside {1, 2, 3} ? er : "R8", "tag", out_tag, et);
        if (ec == 0) chk("R4", "widened top bits", {out_word[19], out_word[15]}, 0);
      end
      // new stimulus for the coming edge
      in_valid = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 9) < 7);
      debug_override = $urandom_range(0, 1);
      acc = in_valid && (!ev || out_ready);
      nv = ev; nw = ew; nc = ec; nt = et; nr = er;
      if (acc) begin
        ref_model(in_insn, debug_override, nw, nc, nt, nr);
        nv = 1;
      end else if (out_ready) nv = 0;
      @(posedge clk);
      ev = nv; ew = nw; ec = nc; et = nt; er = nr;
      @(negedge clk);
      if (acc) begin idx++; in_insn = gen(idx); end
    end
    // reset while holding a result
    in_valid = 1; out_ready = 0; in_insn = 16'hDF12;
    @(negedge clk);
    rst = 1; @(negedge clk);
    chk("R10", "out_valid after mid-run reset", out_valid, 0);
    rst = 0; in_valid = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule